// File: doc/BRIEF.md
# Interrupt-Driven I2C Read Master

This controller sits on the host side of a two-wire serial control port and drains a byte stream from a target. The target signals pending data by pulling an active-low request line. The controller waits for it and then frames a start condition. It sends the 7-bit target address with the read flag set, checks the acknowledge, and shifts in bytes most significant bit first. Each received byte is handed to the host logic on a parallel output together with a single-cycle strobe.

No byte count sets the length of a read. At the last bit of every byte the controller samples the request line again. If the line is still low it acknowledges and reads on. If the line has gone high it declines the byte with a not-acknowledge and closes with a stop. If the address is not acknowledged, the controller stops and retries the whole sequence. A run of failed attempts raises an error flag and returns the controller to idle.

The data line is modelled as open drain: the block only ever pulls it low, and it reads the resolved line back. The serial clock is derived from the system clock. Every bit lasts four quarter phases, and each quarter lasts `quarterDiv + 1` system cycles.

Top module: `i2c_irq_reader`

## Requirements
- R1: Out of reset, and whenever no read session is running, `sclOut` is 1 and `sdaDriveLow` is 0. Out of reset `rxValid` and `addrError` are 0. While `intReqN` stays high no session begins.
- R2: A session begins when `intReqN` is sampled low while idle. It opens with the data line falling while the clock is high. It closes with the data line rising while the clock is high.
- R3: The first byte sent is the 7-bit parameter `DEV_ADDR` followed by a 1 in the least significant position, which is the read flag. It is sent most significant bit first, one bit per clock high phase.
- R4: Outside start and stop conditions, the data line changes only while the clock is low. It holds its value for the whole high phase of every bit.
- R5: Each received byte is assembled most significant bit first from the line value in the clock high phase. It appears on `rxData` with `rxValid` high for exactly one system cycle.
- R6: `intReqN` is sampled at the end of the first high quarter of the eighth data bit. If it is low, the controller holds the data line low through the ninth clock (acknowledge) and reads another byte. If it is high, the controller releases the line in the ninth clock (not-acknowledge) and then sends a stop.
- R7: If the line is high during the ninth clock of the address byte, the controller sends a stop and at once begins a new start and address sequence. This does not wait for `intReqN`. `addrError` stays 0 while fewer than `MAX_RETRY` consecutive address attempts have failed.
- R8: After `MAX_RETRY` consecutive failed address attempts the controller sends a stop, sets `addrError` to 1 and returns to idle. `addrError` stays 1 until a later address is acknowledged, which clears it to 0.
- R9: The clock period of each bit is 4*(`quarterDiv`+1) system cycles, measured from one rising clock edge to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| quarterDiv | input | DIV_W | Quarter-phase length minus one, in system cycles |
| intReqN | input | 1 | Active-low data-pending request from the target |
| sdaIn | input | 1 | Resolved level of the open-drain data line |
| sclOut | output | 1 | Serial clock |
| sdaDriveLow | output | 1 | Pull the data line low when 1, release it when 0 |
| rxData | output | 8 | Last byte received |
| rxValid | output | 1 | One-cycle strobe marking a new byte on rxData |
| addrError | output | 1 | Set after MAX_RETRY failed address attempts in a row |

## Verification
A wrong quarter-phase or bit counter shows within one bit period. The result is a clock period other than four quarters, a data edge inside a clock high phase, or an address byte that decodes to the wrong value. A wrong end-of-byte decision shows in the ninth clock of the byte it affects: the bench compares the acknowledge level against the request line it drove, and it counts the bytes against its queue. Faults in the retry state show within one address attempt, as a missing restart, an early or late error flag, or an error flag that fails to clear.

// File: rtl/i2crd_pkg.sv
package i2crd_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_ADDRACK, ST_DATA, ST_DATAACK, ST_STOP
  } state_e;

  typedef struct packed {
    logic run;       // divider and phase counter active
    logic sclHigh;   // requested clock level
    logic sdaLow;    // requested data pull-down
    logic busCond;   // start or stop framing in progress
    logic shiftIn;   // capture a data bit
    logic loadByte;  // publish the assembled byte
    logic bitAdv;    // step the bit counter
  } ctrl_t;
endpackage

// File: rtl/i2crd_datapath.sv
module i2crd_datapath
  import i2crd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DIV_W-1:0]  quarterDiv,
  input  logic              sdaIn,
  output logic              tick,
  output logic [1:0]        phase,
  output logic [BIT_W-1:0]  bitCnt,
  output logic              sclOut,
  output logic              sdaDriveLow,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid
);
  logic [DIV_W-1:0]  divCnt;
  logic [BYTE_W-1:0] shiftReg;

  assign tick = ctrl.run && (divCnt == quarterDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      phase  <= '0;
    end else if (!ctrl.run) begin
      divCnt <= '0;
      phase  <= '0;
    end else if (tick) begin
      divCnt <= '0;
      phase  <= phase + 2'd1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (ctrl.bitAdv) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
    end else begin
      if (ctrl.shiftIn) shiftReg <= {shiftReg[BYTE_W-2:0], sdaIn};
      rxValid <= ctrl.loadByte;
      if (ctrl.loadByte) rxData <= {shiftReg[BYTE_W-2:0], sdaIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOut      <= 1'b1;
      sdaDriveLow <= 1'b0;
    end else begin
      sclOut      <= ctrl.sclHigh;
      sdaDriveLow <= ctrl.sdaLow;
    end
  end

  // R1: an idle controller leaves both lines released
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.run |=> (sclOut && !sdaDriveLow));

  // R4: a data edge under a high clock is only legal as start or stop framing
  p_sda_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut && $past(sclOut) && (sdaDriveLow != $past(sdaDriveLow))) |-> $past(ctrl.busCond));

  // R5: the byte strobe lasts a single cycle
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
endmodule

// File: rtl/i2crd_control.sv
module i2crd_control
  import i2crd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h4A,
  parameter int         MAX_RETRY = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             intReqN,
  input  logic             sdaIn,
  input  logic             tick,
  input  logic [1:0]       phase,
  input  logic [BIT_W-1:0] bitCnt,
  output ctrl_t            ctrl,
  output logic             addrError
);
  localparam int RETRY_W = $clog2(MAX_RETRY + 1);
  localparam logic [BYTE_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b1};
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BYTE_W - 1);

  state_e             state;
  logic               ackOk;
  logic               moreReg;
  logic               restartReg;
  logic [RETRY_W-1:0] retryCnt;

  logic sampleNow, endOfBit, bitClkHigh;
  assign sampleNow  = tick && (phase == 2'd1);
  assign endOfBit   = tick && (phase == 2'd3);
  assign bitClkHigh = (phase == 2'd1) || (phase == 2'd2);

  always_comb begin
    ctrl          = '0;
    ctrl.run      = (state != ST_IDLE);
    ctrl.sclHigh  = bitClkHigh;
    ctrl.busCond  = (state == ST_START) || (state == ST_STOP);
    ctrl.bitAdv   = ((state == ST_ADDR) || (state == ST_DATA)) && endOfBit;
    ctrl.shiftIn  = (state == ST_DATA) && sampleNow;
    ctrl.loadByte = ctrl.shiftIn && (bitCnt == LAST_BIT);
    case (state)
      ST_IDLE:    ctrl.sclHigh = 1'b1;
      ST_START: begin
        ctrl.sclHigh = (phase != 2'd3);
        ctrl.sdaLow  = phase[1];
      end
      ST_ADDR:    ctrl.sdaLow = !ADDR_BYTE[LAST_BIT - bitCnt];
      ST_DATAACK: ctrl.sdaLow = moreReg;
      ST_STOP: begin
        ctrl.sclHigh = (phase != 2'd0);
        ctrl.sdaLow  = !phase[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      ackOk      <= 1'b0;
      moreReg    <= 1'b0;
      restartReg <= 1'b0;
      retryCnt   <= '0;
      addrError  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:  if (!intReqN) state <= ST_START;
        ST_START: if (endOfBit) state <= ST_ADDR;
        ST_ADDR:  if (endOfBit && bitCnt == LAST_BIT) state <= ST_ADDRACK;
        ST_ADDRACK: begin
          if (sampleNow) ackOk <= !sdaIn;
          if (endOfBit) begin
            if (ackOk) begin
              retryCnt  <= '0;
              addrError <= 1'b0;
              state     <= ST_DATA;
            end else if (retryCnt == RETRY_W'(MAX_RETRY - 1)) begin
              retryCnt   <= '0;
              addrError  <= 1'b1;
              restartReg <= 1'b0;
              state      <= ST_STOP;
            end else begin
              retryCnt   <= retryCnt + 1'b1;
              restartReg <= 1'b1;
              state      <= ST_STOP;
            end
          end
        end
        ST_DATA: begin
          if (sampleNow && bitCnt == LAST_BIT) moreReg <= !intReqN;
          if (endOfBit && bitCnt == LAST_BIT) state <= ST_DATAACK;
        end
        ST_DATAACK: if (endOfBit) begin
          restartReg <= 1'b0;
          state      <= moreReg ? ST_DATA : ST_STOP;
        end
        ST_STOP:  if (endOfBit) state <= restartReg ? ST_START : ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R8: the retry count never reaches its limit without resetting
  p_retry_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt < RETRY_W'(MAX_RETRY));

  // R8: the error flag only rises on the way out through a stop
  p_error_path_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrError) |-> (state == ST_STOP));
endmodule

// File: rtl/i2c_irq_reader.sv
module i2c_irq_reader
  import i2crd_pkg::*;
#(
  parameter int         DIV_W     = 8,
  parameter logic [6:0] DEV_ADDR  = 7'h4A,
  parameter int         MAX_RETRY = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] quarterDiv,
  input  logic             intReqN,
  input  logic             sdaIn,
  output logic             sclOut,
  output logic             sdaDriveLow,
  output logic [7:0]       rxData,
  output logic             rxValid,
  output logic             addrError
);
  ctrl_t            ctrl;
  logic             tick;
  logic [1:0]       phase;
  logic [BIT_W-1:0] bitCnt;

  i2crd_control #(.DEV_ADDR(DEV_ADDR), .MAX_RETRY(MAX_RETRY)) u_ctrl (
    .clk(clk), .rstN(rstN), .intReqN(intReqN), .sdaIn(sdaIn),
    .tick(tick), .phase(phase), .bitCnt(bitCnt),
    .ctrl(ctrl), .addrError(addrError)
  );

  i2crd_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .quarterDiv(quarterDiv), .sdaIn(sdaIn),
    .tick(tick), .phase(phase), .bitCnt(bitCnt),
    .sclOut(sclOut), .sdaDriveLow(sdaDriveLow), .rxData(rxData), .rxValid(rxValid)
  );
endmodule

// File: tb/i2c_irq_reader_tb.sv
module i2c_irq_reader_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] quarterDiv;
  logic       intReqN;
  logic       slaveLow;
  logic       sclOut, sdaDriveLow, rxValid, addrError;
  logic [7:0] rxData;
  wire        sdaBus = !(sdaDriveLow || slaveLow);

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] expQ[$];
  logic [7:0] txQ[$];
  logic prevValid = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_irq_reader #(.DIV_W(8), .DEV_ADDR(7'h4A), .MAX_RETRY(3)) u_dut (
    .clk(clk), .rstN(rstN), .quarterDiv(quarterDiv), .intReqN(intReqN), .sdaIn(sdaBus),
    .sclOut(sclOut), .sdaDriveLow(sdaDriveLow), .rxData(rxData), .rxValid(rxValid),
    .addrError(addrError)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected bytes as the design publishes them
  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid && prevValid) chk(1'b0, "R5", "strobe longer than one cycle", 1, 0);
      if (rxValid) begin
        if (expQ.size() == 0) chk(1'b0, "R5", "unexpected byte", int'(rxData), 0);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          chk(rxData == e, "R5", "received byte", int'(rxData), int'(e));
        end
      end
      prevValid <= rxValid;
    end
  end

  task automatic waitStop();
    forever begin
      @(posedge sdaBus);
      if (sclOut) break;
    end
    chk(sclOut == 1'b1, "R2", "stop with clock high", int'(sclOut), 1);
  endtask

  task automatic slaveSession(input int nNack, input bit errCase);
    int attempt = 0;
    bit done = 0;
    while (!done) begin
      logic [7:0] addr;
      int t0;
      bit ackIt;
      forever begin
        @(negedge sdaBus);
        if (sclOut) break;
      end
      chk(sclOut && sdaDriveLow, "R2", "start framing", int'({sclOut, sdaDriveLow}), 3);
      addr = '0;
      t0 = 0;
      for (int i = 0; i < 8; i++) begin
        logic b;
        @(posedge sclOut);
        if (i == 0) t0 = cyc;
        if (i == 1) chk(cyc - t0 == 4 * (int'(quarterDiv) + 1), "R9", "bit period",
                        cyc - t0, 4 * (int'(quarterDiv) + 1));
        b = sdaBus;
        addr = {addr[6:0], b};
        @(negedge sclOut);
        chk(sdaBus == b, "R4", "data held through clock high", int'(sdaBus), int'(b));
      end
      chk(addr == 8'h95, "R3", "address byte", int'(addr), 8'h95);
      ackIt = (attempt >= nNack);
      @(negedge clk);
      slaveLow = ackIt;
      @(posedge sclOut);
      if (!ackIt && errCase && attempt == nNack - 1) intReqN = 1'b1;
      @(negedge sclOut);
      slaveLow = 1'b0;
      attempt++;
      if (!ackIt) begin
        waitStop();
        if (errCase && attempt == nNack) done = 1;
        else chk(addrError == 1'b0, "R7", "no error before retry limit", int'(addrError), 0);
        continue;
      end
      while (txQ.size() != 0) begin
        logic [7:0] b8;
        bit last;
        b8 = txQ.pop_front();
        last = (txQ.size() == 0);
        for (int i = 7; i >= 0; i--) begin
          slaveLow = !b8[i];
          @(posedge sclOut);
          if (i == 0 && last) intReqN = 1'b1;
          @(negedge sclOut);
        end
        slaveLow = 1'b0;
        @(posedge sclOut);
        chk((sdaBus == 1'b0) == !last, "R6", "ack level in ninth clock", int'(sdaBus), int'(last));
        @(negedge sclOut);
      end
      waitStop();
      done = 1;
    end
  endtask

  task automatic runRead(input int nNack, input bit errCase, input logic [7:0] b0,
                         input logic [7:0] b1, input int nBytes);
    if (nBytes > 0) begin txQ.push_back(b0); expQ.push_back(b0); end
    if (nBytes > 1) begin txQ.push_back(b1); expQ.push_back(b1); end
    @(negedge clk);
    intReqN = 1'b0;
    slaveSession(nNack, errCase);
    repeat (40) @(negedge clk);
  endtask

  task automatic checkIdle(input string req, input int n);
    bit ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!sclOut || sdaDriveLow) ok = 0;
    end
    chk(ok, req, "lines released while idle", int'(ok), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    intReqN = 1'b1;
    slaveLow = 1'b0;
    quarterDiv = 8'd1;
    repeat (5) @(negedge clk);
    chk(sclOut && !sdaDriveLow && !rxValid && !addrError, "R1", "reset state",
        int'({sclOut, sdaDriveLow, rxValid, addrError}), 8);
    rstN = 1'b1;
    checkIdle("R1", 100);

    // several bytes, including all-ones and all-zeros (R5, R6)
    runRead(0, 0, 8'hA5, 8'h3C, 2);
    runRead(0, 0, 8'hFF, 8'h00, 2);
    chk(expQ.size() == 0, "R5", "all bytes delivered", expQ.size(), 0);
    checkIdle("R1", 50);

    // single byte at a slower clock (R9, R6)
    quarterDiv = 8'd2;
    runRead(0, 0, 8'h81, 8'h00, 1);

    // two refused addresses then success (R7)
    runRead(2, 0, 8'h5A, 8'hC3, 2);
    chk(addrError == 1'b0, "R7", "no error after recovered retries", int'(addrError), 0);

    // retry limit reached (R8)
    quarterDiv = 8'd1;
    runRead(3, 1, 8'h00, 8'h00, 0);
    chk(addrError == 1'b1, "R8", "error after retry limit", int'(addrError), 1);
    checkIdle("R8", 60);
    chk(addrError == 1'b1, "R8", "error holds while idle", int'(addrError), 1);

    // next acknowledged address clears the error (R8)
    runRead(0, 0, 8'h6E, 8'h00, 1);
    chk(addrError == 1'b0, "R8", "error cleared by ack", int'(addrError), 0);
    chk(expQ.size() == 0, "R5", "queue drained", expQ.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule